// File: doc/BRIEF.md
# Stop-Mode Wakeup and Recovery Controller

This block decides when a small microcontroller leaves deep sleep, and how. A one-cycle enter-stop strobe gates the system clocks off. While the block is in stop it watches six wake inputs: external reset, low-voltage reset, break, the external IRQ pin, the keyboard interrupt and the timebase rollover. When any of them fires, the block keeps the clocks gated while an oscillator settling counter runs. It then turns the clocks back on and hands the CPU the 16-bit address of the vector it must fetch.

A configuration input chooses the settling time. The long setting is 4096 crystal cycles and suits crystal oscillators. The short setting is 32 cycles. The IRQ pin is asynchronous and active low, so it passes through a two-flop synchronizer and only a falling edge counts as a wake. The other wake inputs are synchronous requests that are active high.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `clk_en` is 1, `vec_valid` is 0 and `vec_addr` is 0x0000.
- R2: An `enter_stop` pulse while running drives `clk_en` to 0 on the next clock edge.
- R3: Wake inputs that arrive while running are ignored. `clk_en` stays 1 and `vec_valid` stays 0.
- R4: With `short_rec`=0, `clk_en` returns to 1 exactly 4096 cycles after the edge on which the wake is accepted.
- R5: With `short_rec`=1, that delay is exactly 32 cycles. The value of `short_rec` is sampled when the count starts.
- R6: Each wake source has its own vector address on `vec_addr`: reset or low-voltage gives 0xFFFE, break gives 0xFFFC, IRQ gives 0xFFFA, keyboard gives 0xFFE0 and timebase gives 0xFFDC.
- R7: When several sources are accepted on the same edge, priority runs reset/low-voltage, then break, then IRQ, then keyboard, then timebase.
- R8: `irq_n` wakes the block only on a high-to-low transition seen through a two-flop synchronizer. The transition is accepted on the third rising edge after the pin falls. A pin that is already low when stop is entered does not wake the block.
- R9: `vec_valid` is a single-cycle pulse. It is high in the same cycle that `clk_en` rises, and `vec_addr` then holds the latched vector.
- R10: During recovery, a reset or low-voltage request restarts the full count and replaces the latched vector with 0xFFFE. Break, IRQ, keyboard and timebase requests during recovery are ignored.
- R11: `clk_en` stays 0 for the whole time the block is in stop or in recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock that counts the settling cycles |
| rst | input | 1 | Synchronous reset, active high |
| enter_stop | input | 1 | Strobe that puts the block into stop |
| short_rec | input | 1 | 1 selects the short settling delay |
| ext_rst | input | 1 | External reset request |
| lvd_rst | input | 1 | Low-voltage reset request |
| brk_req | input | 1 | Break request |
| irq_n | input | 1 | Asynchronous IRQ pin, active low |
| kbd_req | input | 1 | Keyboard interrupt request |
| tbase_roll | input | 1 | Timebase rollover request |
| clk_en | output | 1 | System clock enable |
| vec_valid | output | 1 | One-cycle strobe that marks a valid vector |
| vec_addr | output | 16 | Vector address for the CPU to fetch |

## Verification
Two events can fall on the same clock edge. One is the settling counter reaching its last cycle. The other is a reset request arriving during recovery. To provoke the collision, the bench times a single-cycle `ext_rst` pulse so that it lands on exactly the edge where the count would complete. It then checks that the clocks are not released, that a full new count runs, and that the vector that finally appears is the reset vector. A second directed case injects a break request in the middle of recovery and checks that neither the count nor the vector changes.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_STOP  = 2'd1,
    PM_RECOV = 2'd2
  } pm_state_t;

  localparam int NUM_WAKE = 5;
  localparam int VEC_W    = 16;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin_n};
      prev  <= chain[STAGES-1];
    end
  end

  assign fall = prev & ~chain[STAGES-1];

  // R8: once a falling edge has been flagged, the previous-sample flop must be low next cycle
  assert_edge_consumed_R8: assert property (@(posedge clk) disable iff (rst)
    fall |=> !prev);
endmodule

// File: rtl/wake_prio.sv
module wake_prio
  import stop_wake_pkg::*;
#(
  parameter logic [NUM_WAKE*VEC_W-1:0] VEC_TABLE = '0
) (
  input  logic [NUM_WAKE-1:0] req,
  output logic                hit,
  output logic [VEC_W-1:0]    vec
);
  always_comb begin
    hit = 1'b0;
    vec = '0;
    for (int i = NUM_WAKE - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        vec = VEC_TABLE[i*VEC_W +: VEC_W];
      end
    end
  end
endmodule

// File: rtl/recov_counter.sv
module recov_counter #(
  parameter int LONG_DELAY  = 4096,
  parameter int SHORT_DELAY = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic short_sel,
  output logic done
);
  localparam int CNT_W = $clog2(LONG_DELAY);
  localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_DELAY - 1);
  localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_DELAY - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_m1;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      lim_m1 <= LONG_M1;
      run    <= 1'b0;
    end else if (start) begin
      cnt    <= '0;
      lim_m1 <= short_sel ? SHORT_M1 : LONG_M1;
      run    <= 1'b1;
    end else if (run) begin
      if (cnt == lim_m1) run <= 1'b0;
      else               cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt == lim_m1);

  // R4/R5: the count never passes the limit latched at start
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= lim_m1));
  // R5: a fresh start always begins from zero
  assert_start_zero_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> (run && cnt == '0));
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import stop_wake_pkg::*;
#(
  parameter int          LONG_DELAY  = 4096,
  parameter int          SHORT_DELAY = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VEC_RESET   = 16'hFFFE,
  parameter logic [15:0] VEC_BREAK   = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ     = 16'hFFFA,
  parameter logic [15:0] VEC_KBD     = 16'hFFE0,
  parameter logic [15:0] VEC_TBASE   = 16'hFFDC
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        enter_stop,
  input  logic        short_rec,
  input  logic        ext_rst,
  input  logic        lvd_rst,
  input  logic        brk_req,
  input  logic        irq_n,
  input  logic        kbd_req,
  input  logic        tbase_roll,
  output logic        clk_en,
  output logic        vec_valid,
  output logic [15:0] vec_addr
);
  // index 0 carries the highest priority
  localparam logic [NUM_WAKE*VEC_W-1:0] VEC_TABLE =
    {VEC_TBASE, VEC_KBD, VEC_IRQ, VEC_BREAK, VEC_RESET};

  pm_state_t            state;
  logic                 irq_fall;
  logic                 rst_hit;
  logic [NUM_WAKE-1:0]  wake_req;
  logic                 wake_hit;
  logic [VEC_W-1:0]     wake_vec;
  logic                 cnt_start;
  logic                 cnt_done;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n (irq_n),
    .fall  (irq_fall)
  );

  assign rst_hit  = ext_rst | lvd_rst;
  assign wake_req = {tbase_roll, kbd_req, irq_fall, brk_req, rst_hit};

  wake_prio #(.VEC_TABLE(VEC_TABLE)) u_prio (
    .req (wake_req),
    .hit (wake_hit),
    .vec (wake_vec)
  );

  assign cnt_start = ((state == PM_STOP) && wake_hit) ||
                     ((state == PM_RECOV) && rst_hit);

  recov_counter #(
    .LONG_DELAY  (LONG_DELAY),
    .SHORT_DELAY (SHORT_DELAY)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .start     (cnt_start),
    .short_sel (short_rec),
    .done      (cnt_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PM_RUN;
      clk_en    <= 1'b1;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
    end else begin
      vec_valid <= 1'b0;
      case (state)
        PM_RUN: begin
          if (enter_stop) begin
            state  <= PM_STOP;
            clk_en <= 1'b0;
          end
        end
        PM_STOP: begin
          if (wake_hit) begin
            state    <= PM_RECOV;
            vec_addr <= wake_vec;
          end
        end
        PM_RECOV: begin
          if (rst_hit) begin
            vec_addr <= VEC_RESET;
          end else if (cnt_done) begin
            state     <= PM_RUN;
            clk_en    <= 1'b1;
            vec_valid <= 1'b1;
          end
        end
        default: state <= PM_RUN;
      endcase
    end
  end

  assert_gated_R11: assert property (@(posedge clk) disable iff (rst)
    (state != PM_RUN) |-> !clk_en);
  assert_stop_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (state == PM_RUN && enter_stop) |=> !clk_en);
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);
  assert_release_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en) |-> vec_valid);
  assert_reset_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (state == PM_RECOV && rst_hit) |=> (!clk_en && vec_addr == VEC_RESET));
endmodule

// File: tb/stop_wake_ctrl_tb.sv
module stop_wake_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enter_stop = 1'b0, short_rec = 1'b1;
  logic        ext_rst = 1'b0, lvd_rst = 1'b0, brk_req = 1'b0;
  logic        irq_n = 1'b1, kbd_req = 1'b0, tbase_roll = 1'b0;
  logic        clk_en, vec_valid;
  logic [15:0] vec_addr;
  int          checks = 0, errors = 0;
  bit          done_flag = 1'b0;

  always #5 clk = ~clk;

  stop_wake_ctrl u_dut (
    .clk(clk), .rst(rst), .enter_stop(enter_stop), .short_rec(short_rec),
    .ext_rst(ext_rst), .lvd_rst(lvd_rst), .brk_req(brk_req), .irq_n(irq_n),
    .kbd_req(kbd_req), .tbase_roll(tbase_roll),
    .clk_en(clk_en), .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  // mask bits: 0 ext_rst, 1 lvd_rst, 2 brk, 3 irq, 4 kbd, 5 timebase
  function automatic logic [15:0] exp_vec(int m);
    if (m[0] || m[1]) return 16'hFFFE;
    if (m[2])         return 16'hFFFC;
    if (m[3])         return 16'hFFFA;
    if (m[4])         return 16'hFFE0;
    return 16'hFFDC;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_direct(int m);
    ext_rst = m[0]; lvd_rst = m[1]; brk_req = m[2];
    kbd_req = m[4]; tbase_roll = m[5];
  endtask

  task automatic enter_stop_mode();
    repeat (3) @(negedge clk);
    enter_stop = 1'b1;
    @(negedge clk);
    enter_stop = 1'b0;
    chk(clk_en == 1'b0, "R2 clk_en after stop strobe", clk_en, 0);
  endtask

  // called at a negedge right after the accepted wake's first following edge
  task automatic measure(int lows, logic [15:0] vexp, string tag);
    int n = 0;
    while (!clk_en && n < 10000) begin
      if (vec_valid) chk(0, {tag, " R11 strobe while gated"}, 1, 0);
      n++;
      @(negedge clk);
    end
    chk(n == lows, {tag, " R4/R5 gated cycles"}, n, lows);
    chk(vec_valid == 1'b1, {tag, " R9 strobe with release"}, vec_valid, 1);
    chk(vec_addr == vexp, {tag, " R6/R7 vector"}, vec_addr, vexp);
    @(negedge clk);
    chk(vec_valid == 1'b0 && clk_en == 1'b1, {tag, " R9 strobe one cycle"},
        {clk_en, vec_valid}, 2);
    chk(vec_addr == vexp, {tag, " R9 vector held"}, vec_addr, vexp);
  endtask

  task automatic do_wake(int m, bit sh, string tag);
    short_rec = sh;
    enter_stop_mode();
    if (m[3]) begin
      irq_n = 1'b0;            // R8: accepted on third edge after the fall
      @(negedge clk);
      @(negedge clk);
    end
    drive_direct(m);
    @(negedge clk);
    drive_direct(0);
    measure(sh ? 32 : 4096, exp_vec(m), tag);
    irq_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(clk_en == 1'b1 && vec_valid == 1'b0 && vec_addr == 16'h0,
        "R1 reset state", {clk_en, vec_valid}, 2);

    // R3: wake inputs while running are ignored
    drive_direct(6'b110101);
    @(negedge clk);
    drive_direct(0);
    irq_n = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk(clk_en == 1'b1 && vec_valid == 1'b0, "R3 ignored while running",
          {clk_en, vec_valid}, 2);
    end
    // R8: pin already low when stop is entered gives no wake
    short_rec = 1'b1;
    enter_stop_mode();
    repeat (50) @(negedge clk);
    chk(clk_en == 1'b0, "R8 low level does not wake", clk_en, 0);
    kbd_req = 1'b1;
    @(negedge clk);
    kbd_req = 1'b0;
    measure(32, 16'hFFE0, "R8 kbd after low pin");
    irq_n = 1'b1;

    // R6: each source alone
    do_wake(6'b000001, 1'b1, "R6 ext_rst");
    do_wake(6'b000010, 1'b1, "R6 lvd_rst");
    do_wake(6'b000100, 1'b1, "R6 break");
    do_wake(6'b001000, 1'b1, "R6 R8 irq");
    do_wake(6'b010000, 1'b1, "R6 kbd");
    do_wake(6'b100000, 1'b1, "R6 timebase");
    // R7: simultaneous sources
    do_wake(6'b111100, 1'b1, "R7 brk wins");
    do_wake(6'b111000, 1'b1, "R7 irq wins");
    do_wake(6'b110000, 1'b1, "R7 kbd wins");
    do_wake(6'b101010, 1'b1, "R7 lvd wins");
    // R4: long delay
    do_wake(6'b100000, 1'b0, "R4 long");

    // R10: reset on the very edge where the count would end
    short_rec = 1'b1;
    enter_stop_mode();
    kbd_req = 1'b1;
    @(negedge clk);
    kbd_req = 1'b0;
    repeat (31) @(negedge clk);
    chk(clk_en == 1'b0, "R10 still gated before collision", clk_en, 0);
    ext_rst = 1'b1;
    @(negedge clk);
    ext_rst = 1'b0;
    measure(32, 16'hFFFE, "R10 restart on completion edge");

    // R10: break during recovery is ignored
    enter_stop_mode();
    kbd_req = 1'b1;
    @(negedge clk);
    kbd_req = 1'b0;
    repeat (9) @(negedge clk);
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    measure(22, 16'hFFE0, "R10 break ignored in recovery");

    // random masks, short delay (R5, R6, R7)
    void'($urandom(32'd2024));
    for (int t = 0; t < 30; t++) begin
      int m = $urandom_range(1, 63);
      do_wake(m, 1'b1, "R5 R7 random");
    end

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule